// File: doc/BRIEF.md
# Condition-Result Fail-First Vector Length Truncation Unit

This block steps through a vector of condition-register results, one element per clock. For each element it picks one condition bit out of that element's result and compares it with a polarity flag. The first element whose bit disagrees with the flag ends the loop. The block then reports a shortened vector length. A two-bit mode select sets the policy. One code counts the failing element in the new length, another leaves it out, and the remaining codes turn truncation off.

The operation that produces each result sits outside the block. The unit drives an element index with a valid flag. In the same cycle the surrounding logic returns that element's result in one of two forms: a four-bit field, or a single bit. In field mode a two-bit selector picks the tested bit out of the field. In bit mode the single bit itself is tested. A per-element enable mask can skip elements. A write strobe marks each element whose result should be committed. When the loop ends, `done` pulses for one cycle together with the new length.

Top module: `crff_trunc_unit`

## Requirements
- R1: After reset, `done`, `elem_vld` and `wr_en` are low and `vl_out` is 0.
- R2: `mode_sel` 2'b01 selects fail-first with the failing element excluded, so `vl_out` = i for a failure at index i. `mode_sel` 2'b10 selects fail-first with the failing element included, so `vl_out` = i+1.
- R3: `mode_sel` 2'b00 or 2'b11 disables the test. Every enabled element is written and `vl_out` equals `vl_in`.
- R4: With `field_op`=0 the tested bit is `res_bit`.
- R5: With `field_op`=1 the tested bit is `res_field[crbit]`, where `crbit` is an index from 0 to 3 into the four-bit field.
- R6: An element fails when its tested bit differs from `inv`. An element whose tested bit equals `inv` passes.
- R7: Element i is presented on `elem_idx` with `elem_vld` high exactly i+1 cycles after the start edge. Each element takes one cycle. No element after a failing one is presented or written. `done` rises one cycle after the last presented element.
- R8: `wr_en` is high for each enabled element that passes. A failing element is written only when `mode_sel` is 2'b10.
- R9: An element with `en_mask[i]`=0 is neither tested nor written, and it cannot truncate the vector.
- R10: If no enabled element fails, `vl_out` equals `vl_in`.
- R11: A start with `vl_in`=0 raises `done` in the next cycle with `vl_out`=0 and presents no element.
- R12: `done` is high for exactly one cycle. `vl_out` is valid while `done` is high and keeps its value until the next completion.
- R13: A `start` pulse while a loop is in progress is ignored. The running loop keeps the configuration captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begins a loop when idle; captures all configuration inputs |
| vl_in | input | VLW | Input vector length, 0 to MAXVL |
| mode_sel | input | 2 | 01: fail-first, exclusive; 10: fail-first, inclusive; 00/11: no test |
| field_op | input | 1 | 1: result is a four-bit field; 0: result is a single bit |
| inv | input | 1 | Value the tested bit must have to pass |
| crbit | input | 2 | Index of the tested bit within the field (field mode) |
| en_mask | input | MAXVL | Per-element enable; bit i gates element i |
| res_field | input | 4 | Field result of the element on `elem_idx` |
| res_bit | input | 1 | Single-bit result of the element on `elem_idx` |
| elem_idx | output | IDXW | Index of the element being evaluated |
| elem_vld | output | 1 | An element is being evaluated this cycle |
| wr_en | output | 1 | Commit the result of the element on `elem_idx` |
| vl_out | output | VLW | Resulting vector length |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `vl_in` never exceeds MAXVL when an idle start is accepted. They also assume that the result inputs are a same-cycle function of `elem_idx`, so each element is judged on its own result. The stimulus uses lengths from 0 up to exactly MAXVL. The bench drives `res_field` and `res_bit` from per-element tables indexed by the block's own `elem_idx`. It changes `start` and the configuration only on falling edges, and it pulses `start` mid-loop only in the busy-ignore case.

// File: rtl/crff_pkg.sv
package crff_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } crff_state_e;

  // Per-loop configuration captured at start
  typedef struct packed {
    logic       ff_on;       // truncation enabled
    logic       incl;        // failing element counted in result
    logic       field_op;    // 1: four-bit field result, 0: single bit
    logic       inv;         // pass polarity
    logic [1:0] crbit;       // bit index in field mode
  } crff_cfg_t;

  function automatic crff_cfg_t crff_decode(input logic [1:0] msel,
                                            input logic       fop,
                                            input logic       pol,
                                            input logic [1:0] sel);
    crff_cfg_t c;
    c.ff_on    = (msel == 2'b01) || (msel == 2'b10);
    c.incl     = (msel == 2'b10);
    c.field_op = fop;
    c.inv      = pol;
    c.crbit    = sel;
    return c;
  endfunction

endpackage

// File: rtl/crff_cfg_reg.sv
module crff_cfg_reg
  import crff_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int VLW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       mode_sel,
  input  logic             field_op,
  input  logic             inv,
  input  logic [1:0]       crbit,
  input  logic [MAXVL-1:0] en_mask,
  input  logic [VLW-1:0]   vl_in,
  output crff_cfg_t        cfg_q,
  output logic [MAXVL-1:0] mask_q,
  output logic [VLW-1:0]   vl_q
);

  crff_cfg_t        cfg_n;
  logic [MAXVL-1:0] mask_n;
  logic [VLW-1:0]   vl_n;

  always_comb begin
    cfg_n  = cfg_q;
    mask_n = mask_q;
    vl_n   = vl_q;
    if (load) begin
      cfg_n  = crff_decode(mode_sel, field_op, inv, crbit);
      mask_n = en_mask;
      vl_n   = vl_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
      vl_q   <= '0;
    end else begin
      cfg_q  <= cfg_n;
      mask_q <= mask_n;
      vl_q   <= vl_n;
    end
  end

endmodule

// File: rtl/crff_bit_test.sv
module crff_bit_test
  import crff_pkg::*;
(
  input  crff_cfg_t  cfg,
  input  logic       elem_on,
  input  logic [3:0] res_field,
  input  logic       res_bit,
  output logic       fail,
  output logic       wr
);

  logic tested;

  always_comb begin
    if (cfg.field_op) tested = res_field[cfg.crbit];
    else              tested = res_bit;
    fail = elem_on && cfg.ff_on && (tested != cfg.inv);
    wr   = elem_on && (!fail || cfg.incl);
  end

endmodule

// File: rtl/crff_seq.sv
module crff_seq
  import crff_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int VLW   = $clog2(MAXVL + 1),
  parameter int IDXW  = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl_in,
  input  logic [VLW-1:0]  vl_q,
  input  logic            incl,
  input  logic            fail,
  output logic            load,
  output logic            running,
  output logic [IDXW-1:0] idx,
  output logic            done,
  output logic [VLW-1:0]  vl_out
);

  crff_state_e     st_q, st_n;
  logic [IDXW-1:0] idx_n;
  logic [VLW-1:0]  vl_n;
  logic            vl_en;
  logic [VLW-1:0]  idx_ext;
  logic            last;

  assign idx_ext = VLW'(idx);
  assign last    = (idx_ext == vl_q - VLW'(1));
  assign running = (st_q == ST_RUN);
  assign done    = (st_q == ST_FIN);
  assign load    = (st_q == ST_IDLE) && start;

  always_comb begin
    st_n  = st_q;
    idx_n = idx;
    vl_n  = vl_out;
    vl_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          idx_n = '0;
          if (vl_in == '0) begin
            st_n  = ST_FIN;
            vl_en = 1'b1;
            vl_n  = '0;
          end else begin
            st_n = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (fail) begin
          st_n  = ST_FIN;
          vl_en = 1'b1;
          vl_n  = incl ? idx_ext + VLW'(1) : idx_ext;
        end else if (last) begin
          st_n  = ST_FIN;
          vl_en = 1'b1;
          vl_n  = vl_q;
        end else begin
          idx_n = idx + IDXW'(1);
        end
      end
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx    <= '0;
      vl_out <= '0;
    end else begin
      st_q <= st_n;
      idx  <= idx_n;
      if (vl_en) vl_out <= vl_n;
    end
  end

  assert_vl_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (vl_in <= VLW'(MAXVL)));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_vl_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(vl_out));

  assert_zero_vl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (vl_in == '0)) |=> (done && (vl_out == '0)));

  assert_idx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fail && !last) |=> (running && (idx == $past(idx) + IDXW'(1))));

  assert_stop_on_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && fail) |=> (done && !running));

  assert_full_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fail && last) |=> (done && (vl_out == $past(vl_q))));

  assert_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vl_out <= vl_q));

endmodule

// File: rtl/crff_trunc_unit.sv
module crff_trunc_unit
  import crff_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int VLW   = $clog2(MAXVL + 1),
  parameter int IDXW  = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl_in,
  input  logic [1:0]       mode_sel,
  input  logic             field_op,
  input  logic             inv,
  input  logic [1:0]       crbit,
  input  logic [MAXVL-1:0] en_mask,
  input  logic [3:0]       res_field,
  input  logic             res_bit,
  output logic [IDXW-1:0]  elem_idx,
  output logic             elem_vld,
  output logic             wr_en,
  output logic [VLW-1:0]   vl_out,
  output logic             done
);

  crff_cfg_t        cfg_q;
  logic [MAXVL-1:0] mask_q;
  logic [VLW-1:0]   vl_q;
  logic             load;
  logic             running;
  logic             elem_on;
  logic             tst_fail;
  logic             tst_wr;

  crff_cfg_reg #(.MAXVL(MAXVL), .VLW(VLW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .mode_sel (mode_sel),
    .field_op (field_op),
    .inv      (inv),
    .crbit    (crbit),
    .en_mask  (en_mask),
    .vl_in    (vl_in),
    .cfg_q    (cfg_q),
    .mask_q   (mask_q),
    .vl_q     (vl_q)
  );

  assign elem_on = running && mask_q[elem_idx];

  crff_bit_test u_test (
    .cfg       (cfg_q),
    .elem_on   (elem_on),
    .res_field (res_field),
    .res_bit   (res_bit),
    .fail      (tst_fail),
    .wr        (tst_wr)
  );

  crff_seq #(.MAXVL(MAXVL), .VLW(VLW), .IDXW(IDXW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .vl_in   (vl_in),
    .vl_q    (vl_q),
    .incl    (cfg_q.incl),
    .fail    (tst_fail),
    .load    (load),
    .running (running),
    .idx     (elem_idx),
    .done    (done),
    .vl_out  (vl_out)
  );

  assign elem_vld = running;
  assign wr_en    = running && tst_wr;

  assert_fail_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_vld && tst_fail) |=>
      (done && (vl_out == VLW'($past(elem_idx)) + VLW'($past(cfg_q.incl)))));

  assert_cfg_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_vld && start) |=> ($stable(cfg_q) && $stable(vl_q) && $stable(mask_q)));

  assert_no_wr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  assert_notest_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_vld && !cfg_q.ff_on) |-> !tst_fail);

endmodule

// File: tb/tb_crff_trunc_unit.sv
`timescale 1ns/1ps
module tb_crff_trunc_unit;
  localparam int MAXVL = 64;
  localparam int VLW   = $clog2(MAXVL + 1);
  localparam int IDXW  = $clog2(MAXVL);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [VLW-1:0]   vl_in;
  logic [1:0]       mode_sel;
  logic             field_op;
  logic             inv;
  logic [1:0]       crbit;
  logic [MAXVL-1:0] en_mask;
  logic [3:0]       res_field;
  logic             res_bit;
  logic [IDXW-1:0]  elem_idx;
  logic             elem_vld;
  logic             wr_en;
  logic [VLW-1:0]   vl_out;
  logic             done;

  logic [3:0]       fld [MAXVL];
  logic [MAXVL-1:0] bits;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  crff_trunc_unit #(.MAXVL(MAXVL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
    .mode_sel(mode_sel), .field_op(field_op), .inv(inv), .crbit(crbit),
    .en_mask(en_mask), .res_field(res_field), .res_bit(res_bit),
    .elem_idx(elem_idx), .elem_vld(elem_vld), .wr_en(wr_en),
    .vl_out(vl_out), .done(done)
  );

  always_comb begin
    res_field = fld[elem_idx];
    res_bit   = bits[elem_idx];
  end

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_data();
    for (int i = 0; i < MAXVL; i++) fld[i] = 4'h0;
    bits = '0;
  endtask

  // Runs one loop and checks length, writes, presented elements, latency, pulse.
  task automatic run_case(input string req, input int vl, input logic [1:0] msel,
                          input logic fop, input logic pol, input logic [1:0] cb,
                          input logic [MAXVL-1:0] mask, input bit glitch);
    logic [MAXVL-1:0] exp_wr = '0, got_wr = '0, got_pres = '0, exp_pres = '0;
    int  exp_vl = vl;
    int  last = vl - 1;
    int  cnt = 0;
    logic ffon = (msel == 2'b01) || (msel == 2'b10);
    logic inc  = (msel == 2'b10);
    logic [VLW-1:0] vl_seen;
    for (int i = 0; i < vl; i++) begin
      logic tb;
      exp_pres[i] = 1'b1;
      if (!mask[i]) continue;
      tb = fop ? fld[i][cb] : bits[i];
      if (ffon && (tb != pol)) begin
        if (inc) exp_wr[i] = 1'b1;
        exp_vl = inc ? i + 1 : i;
        last = i;
        break;
      end
      exp_wr[i] = 1'b1;
    end
    for (int i = last + 1; i < MAXVL; i++) exp_pres[i] = 1'b0;

    @(negedge clk);
    vl_in = VLW'(vl); mode_sel = msel; field_op = fop; inv = pol;
    crbit = cb; en_mask = mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 200) begin
      if (elem_vld) got_pres[elem_idx] = 1'b1;
      if (wr_en) got_wr[elem_idx] = 1'b1;
      if (glitch && cnt == 3) begin
        start = 1'b1; vl_in = VLW'(3); mode_sel = 2'b10; inv = ~pol; en_mask = '0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk(req, "done reached", longint'(done), 1);
    chk("R7", "latency", cnt, (vl == 0) ? 1 : last + 2);
    chk(req, "vl_out", vl_out, exp_vl);
    chk("R8", "write set", got_wr, exp_wr);
    chk("R7", "presented set", got_pres, exp_pres);
    vl_seen = vl_out;
    @(negedge clk);
    chk("R12", "done pulse width", done, 0);
    chk("R12", "vl_out held", vl_out, vl_seen);
  endtask

  task automatic t_reset();
    chk("R1", "done", done, 0);
    chk("R1", "elem_vld", elem_vld, 0);
    chk("R1", "wr_en", wr_en, 0);
    chk("R1", "vl_out", vl_out, 0);
  endtask

  task automatic t_bit_nofail();
    clear_data();
    run_case("R10", 8, 2'b01, 1'b0, 1'b0, 2'd0, '1, 1'b0);
  endtask

  task automatic t_bit_fail_modes();
    clear_data(); bits[5] = 1'b1;
    run_case("R2", 12, 2'b01, 1'b0, 1'b0, 2'd0, '1, 1'b0);
    run_case("R2", 12, 2'b10, 1'b0, 1'b0, 2'd0, '1, 1'b0);
    run_case("R4", 12, 2'b10, 1'b1, 1'b0, 2'd0, '1, 1'b0);
  endtask

  task automatic t_field_sel();
    for (int k = 0; k < 4; k++) begin
      clear_data();
      fld[1] = ~(4'b0001 << k);
      fld[2 + k] = 4'b0001 << k;
      bits[0] = 1'b1;
      run_case("R5", 10, 2'b01, 1'b1, 1'b0, 2'(k), '1, 1'b0);
    end
  endtask

  task automatic t_inverted();
    clear_data(); bits = '1; bits[4] = 1'b0;
    run_case("R6", 9, 2'b10, 1'b0, 1'b1, 2'd0, '1, 1'b0);
    clear_data(); bits = '1;
    run_case("R6", 9, 2'b01, 1'b0, 1'b1, 2'd0, '1, 1'b0);
  endtask

  task automatic t_masked();
    logic [MAXVL-1:0] m = '1;
    clear_data(); bits[2] = 1'b1; bits[6] = 1'b1;
    m[2] = 1'b0; m[4] = 1'b0;
    run_case("R9", 10, 2'b01, 1'b0, 1'b0, 2'd0, m, 1'b0);
  endtask

  task automatic t_notest();
    logic [MAXVL-1:0] m = '1;
    clear_data(); bits = '1; m[3] = 1'b0;
    run_case("R3", 7, 2'b00, 1'b0, 1'b0, 2'd0, m, 1'b0);
    run_case("R3", 7, 2'b11, 1'b0, 1'b0, 2'd0, '1, 1'b0);
  endtask

  task automatic t_zero_len();
    clear_data();
    run_case("R11", 0, 2'b10, 1'b0, 1'b0, 2'd0, '1, 1'b0);
  endtask

  task automatic t_edges();
    clear_data(); bits[0] = 1'b1;
    run_case("R2", 5, 2'b01, 1'b0, 1'b0, 2'd0, '1, 1'b0);
    run_case("R2", 5, 2'b10, 1'b0, 1'b0, 2'd0, '1, 1'b0);
    clear_data(); bits[MAXVL-1] = 1'b1;
    run_case("R2", MAXVL, 2'b10, 1'b0, 1'b0, 2'd0, '1, 1'b0);
    run_case("R2", MAXVL, 2'b01, 1'b0, 1'b0, 2'd0, '1, 1'b0);
    clear_data();
    run_case("R10", MAXVL, 2'b01, 1'b0, 1'b0, 2'd0, '1, 1'b0);
  endtask

  task automatic t_busy_start();
    clear_data();
    run_case("R13", 10, 2'b01, 1'b0, 1'b0, 2'd0, '1, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; vl_in = '0; mode_sel = 2'b00; field_op = 1'b0;
    inv = 1'b0; crbit = 2'd0; en_mask = '0;
    clear_data();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bit_nofail();
    t_bit_fail_modes();
    t_field_sel();
    t_inverted();
    t_masked();
    t_notest();
    t_zero_len();
    t_edges();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule